// File: doc/BRIEF.md
# Display controller interrupt unit

This block collects six fault and progress events from a display controller and merges them into one interrupt request line. It watches qualifying strobes from the DMA engine, the pixel FIFO, the serializer and the timing generator. Each event is derived from its own condition, and the block records it in a sticky status bit. The status bits are combined with a software-controlled mask to form the request.

Software uses a simple read/write register port. The mask is never written directly. Three write-only strobe registers set mask bits, clear mask bits and acknowledge status bits, and two read-only registers return the mask and the status. All logic, including every event input, runs on the display core clock.

Top module: `disp_irq_ctrl`

## Requirements
- R1: After reset the mask reads 0, the status reads 0 and `irq_o` is low.
- R2: Status bit 0 (bus fault) sets when `dma_err_i` and `dma_xfer_i` are high in the same cycle. An error strobe without an active transfer has no effect.
- R3: Status bit 1 (FIFO underflow) sets on `fifo_rd_i` with `fifo_empty_i` high. Status bit 2 (FIFO overwrite) sets on `fifo_wr_i` with `fifo_full_i` high. A read or write without the matching condition, or the condition without an access, has no effect.
- R4: Status bit 3 (frame end) sets when `base_upd_i` is high.
- R5: Status bit 4 (line end) sets when `line_blank_i` is high and `dma_busy_i` is low. Status bit 5 (last line end) sets under the same condition with `last_line_i` also high. A blanking strobe while the DMA is busy sets neither bit.
- R6: Status bits are sticky and are set whatever the mask holds. A read of address 4 returns the status in bits [5:0], with all higher bits zero.
- R7: A write to address 0 sets each mask bit whose data bit is one and leaves the others unchanged. A read of address 3 returns the mask in bits [5:0], with higher bits zero.
- R8: A write to address 1 clears each mask bit whose data bit is one and leaves the others unchanged.
- R9: A write to address 2 clears each status bit whose data bit is one. If an event for the same bit occurs in the same cycle, the bit stays set.
- R10: `irq_o` is high in the cycle after one in which some status bit and its mask bit are both set, and low otherwise.
- R11: Reads of addresses 5 to 7 return zero. Writes to addresses 3 to 7 change neither the mask nor the status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Display core clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Register access request |
| we_i | input | 1 | Write when high, read when low |
| addr_i | input | ADDR_W | Register word address |
| wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Read data, valid in the cycle of a read access |
| dma_err_i | input | 1 | Error response seen by the DMA |
| dma_xfer_i | input | 1 | DMA data transfer in progress |
| fifo_rd_i | input | 1 | Serializer reads the FIFO |
| fifo_empty_i | input | 1 | FIFO is empty |
| fifo_wr_i | input | 1 | DMA writes the FIFO |
| fifo_full_i | input | 1 | FIFO is full |
| base_upd_i | input | 1 | DMA reloads its frame base pointers |
| line_blank_i | input | 1 | Line blanking point reached |
| last_line_i | input | 1 | Current line is the last of the frame |
| dma_busy_i | input | 1 | DMA is active |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench builds the block with its default parameters: a 3-bit address and a 32-bit data word. The 3-bit address lets the bench reach the three unused offsets as well as the five mapped ones. It reads them back as zero and writes to them to show that nothing changes. The 32-bit word leaves 26 data bits above the six sources, so every read also checks that those upper bits stay zero and that a wide write affects only the six real bits.

// File: rtl/disp_irq_pkg.sv
package disp_irq_pkg;
  localparam int unsigned NUM_SRC = 6;

  typedef enum int unsigned {
    SRC_BUS_FAULT  = 0,
    SRC_FIFO_UNDR  = 1,
    SRC_FIFO_OVWR  = 2,
    SRC_FRAME_END  = 3,
    SRC_LINE_END   = 4,
    SRC_LAST_LINE  = 5
  } src_e;

  typedef logic [NUM_SRC-1:0] src_vec_t;

  localparam int unsigned ADR_MASK_SET = 0;
  localparam int unsigned ADR_MASK_CLR = 1;
  localparam int unsigned ADR_STAT_ACK = 2;
  localparam int unsigned ADR_MASK_RD  = 3;
  localparam int unsigned ADR_STAT_RD  = 4;
endpackage

// File: rtl/disp_irq_detect.sv
module disp_irq_detect
  import disp_irq_pkg::*;
(
  input  logic     dma_err_i,
  input  logic     dma_xfer_i,
  input  logic     fifo_rd_i,
  input  logic     fifo_empty_i,
  input  logic     fifo_wr_i,
  input  logic     fifo_full_i,
  input  logic     base_upd_i,
  input  logic     line_blank_i,
  input  logic     last_line_i,
  input  logic     dma_busy_i,
  output src_vec_t evt_o
);
  logic blank_idle;

  // blanking only counts once the DMA has gone quiet
  assign blank_idle = line_blank_i & ~dma_busy_i;

  assign evt_o[SRC_BUS_FAULT] = dma_err_i & dma_xfer_i;
  assign evt_o[SRC_FIFO_UNDR] = fifo_rd_i & fifo_empty_i;
  assign evt_o[SRC_FIFO_OVWR] = fifo_wr_i & fifo_full_i;
  assign evt_o[SRC_FRAME_END] = base_upd_i;
  assign evt_o[SRC_LINE_END]  = blank_idle;
  assign evt_o[SRC_LAST_LINE] = blank_idle & last_line_i;
endmodule

// File: rtl/disp_irq_regif.sv
module disp_irq_regif
  import disp_irq_pkg::*;
#(
  parameter int unsigned ADDR_W = 3,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  src_vec_t          mask_i,
  input  src_vec_t          status_i,
  output src_vec_t          set_mask_o,
  output src_vec_t          clr_mask_o,
  output src_vec_t          ack_stat_o,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int unsigned PAD_W = DATA_W - NUM_SRC;

  logic     wr_acc, rd_acc;
  src_vec_t wbits;
  logic     unused_wdata_hi;

  assign wr_acc = req_i & we_i;
  assign rd_acc = req_i & ~we_i;
  assign wbits  = wdata_i[NUM_SRC-1:0];
  assign unused_wdata_hi = ^wdata_i[DATA_W-1:NUM_SRC];

  assign set_mask_o = (wr_acc && addr_i == ADDR_W'(ADR_MASK_SET)) ? wbits : '0;
  assign clr_mask_o = (wr_acc && addr_i == ADDR_W'(ADR_MASK_CLR)) ? wbits : '0;
  assign ack_stat_o = (wr_acc && addr_i == ADDR_W'(ADR_STAT_ACK)) ? wbits : '0;

  always_comb begin
    rdata_o = '0;
    if (rd_acc) begin
      if (addr_i == ADDR_W'(ADR_MASK_RD))      rdata_o = {{PAD_W{1'b0}}, mask_i};
      else if (addr_i == ADDR_W'(ADR_STAT_RD)) rdata_o = {{PAD_W{1'b0}}, status_i};
    end
  end

  // R7 R8 R9: one access drives at most one strobe group
  a_r7_one_strobe_group: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({|set_mask_o, |clr_mask_o, |ack_stat_o}));

  // R11: reads never raise a strobe
  a_r11_read_no_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_acc |-> (set_mask_o == '0 && clr_mask_o == '0 && ack_stat_o == '0));
endmodule

// File: rtl/disp_irq_core.sv
module disp_irq_core
  import disp_irq_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  src_vec_t evt_i,
  input  src_vec_t set_mask_i,
  input  src_vec_t clr_mask_i,
  input  src_vec_t ack_stat_i,
  output src_vec_t mask_o,
  output src_vec_t status_o,
  output logic     irq_o
);
  src_vec_t mask_q, status_q;
  logic     irq_q;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)            mask_q[i] <= 1'b0;
      else if (set_mask_i[i]) mask_q[i] <= 1'b1;
      else if (clr_mask_i[i]) mask_q[i] <= 1'b0;
    end

    // event beats a simultaneous acknowledge
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)            status_q[i] <= 1'b0;
      else if (evt_i[i])      status_q[i] <= 1'b1;
      else if (ack_stat_i[i]) status_q[i] <= 1'b0;
    end

    a_r9_event_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
      evt_i[i] |=> status_q[i]);
    a_r6_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (status_q[i] && !ack_stat_i[i]) |=> status_q[i]);
    a_r7_set_mask: assert property (@(posedge clk_i) disable iff (!rst_ni)
      set_mask_i[i] |=> mask_q[i]);
    a_r8_clr_mask: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (clr_mask_i[i] && !set_mask_i[i]) |=> !mask_q[i]);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= |(status_q & mask_q);
  end

  assign mask_o   = mask_q;
  assign status_o = status_q;
  assign irq_o    = irq_q;

  a_r10_masked_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((status_q & mask_q) == '0) |=> !irq_o);
  a_r6_mask_no_effect_on_status: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_i == '0 && ack_stat_i == '0) |=> status_q == $past(status_q));
endmodule

// File: rtl/disp_irq_ctrl.sv
module disp_irq_ctrl
  import disp_irq_pkg::*;
#(
  parameter int unsigned ADDR_W = 3,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              dma_err_i,
  input  logic              dma_xfer_i,
  input  logic              fifo_rd_i,
  input  logic              fifo_empty_i,
  input  logic              fifo_wr_i,
  input  logic              fifo_full_i,
  input  logic              base_upd_i,
  input  logic              line_blank_i,
  input  logic              last_line_i,
  input  logic              dma_busy_i,
  output logic              irq_o
);
  src_vec_t evt, set_mask, clr_mask, ack_stat, mask, status;

  disp_irq_detect u_detect (
    .dma_err_i    (dma_err_i),
    .dma_xfer_i   (dma_xfer_i),
    .fifo_rd_i    (fifo_rd_i),
    .fifo_empty_i (fifo_empty_i),
    .fifo_wr_i    (fifo_wr_i),
    .fifo_full_i  (fifo_full_i),
    .base_upd_i   (base_upd_i),
    .line_blank_i (line_blank_i),
    .last_line_i  (last_line_i),
    .dma_busy_i   (dma_busy_i),
    .evt_o        (evt)
  );

  disp_irq_regif #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regif (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .req_i      (req_i),
    .we_i       (we_i),
    .addr_i     (addr_i),
    .wdata_i    (wdata_i),
    .mask_i     (mask),
    .status_i   (status),
    .set_mask_o (set_mask),
    .clr_mask_o (clr_mask),
    .ack_stat_o (ack_stat),
    .rdata_o    (rdata_o)
  );

  disp_irq_core u_core (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .evt_i      (evt),
    .set_mask_i (set_mask),
    .clr_mask_i (clr_mask),
    .ack_stat_i (ack_stat),
    .mask_o     (mask),
    .status_o   (status),
    .irq_o      (irq_o)
  );

  // R5: a last-line event always comes with a line-end event
  a_r5_last_implies_line: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt[SRC_LAST_LINE] |=> (status[SRC_LINE_END] && status[SRC_LAST_LINE]));
endmodule

// File: tb/tb_disp_irq_ctrl.sv
`timescale 1ns/1ps
module tb_disp_irq_ctrl;
  localparam int unsigned ADDR_W = 3;
  localparam int unsigned DATA_W = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req = 1'b0, we = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic [DATA_W-1:0] wdata = '0;
  logic [DATA_W-1:0] rdata;
  logic irq;
  // ev bit map: 0 err,1 xfer,2 rd,3 empty,4 wr,5 full,6 base_upd,7 blank,8 last,9 busy
  logic [9:0] ev = '0;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  disp_irq_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) dut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata),
    .dma_err_i(ev[0]), .dma_xfer_i(ev[1]), .fifo_rd_i(ev[2]), .fifo_empty_i(ev[3]),
    .fifo_wr_i(ev[4]), .fifo_full_i(ev[5]), .base_upd_i(ev[6]), .line_blank_i(ev[7]),
    .last_line_i(ev[8]), .dma_busy_i(ev[9]), .irq_o(irq)
  );

  task automatic chk(input string tag, input logic [DATA_W-1:0] act, input logic [DATA_W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [DATA_W-1:0] d);
    @(negedge clk); req = 1; we = 1; addr = ADDR_W'(a); wdata = d;
    @(negedge clk); req = 0; we = 0; wdata = '0;
  endtask

  task automatic rd(input int a, output logic [DATA_W-1:0] d);
    @(negedge clk); req = 1; we = 0; addr = ADDR_W'(a);
    #1 d = rdata;
    req = 0;
  endtask

  task automatic pulse(input logic [9:0] v);
    @(negedge clk); ev = v;
    @(negedge clk); ev = '0;
  endtask

  task automatic t_reset;
    logic [DATA_W-1:0] d;
    rd(3, d); chk("R1 mask", d, 0);
    rd(4, d); chk("R1 status", d, 0);
    chk("R1 irq", irq, 0);
  endtask

  task automatic t_bus_fault;
    logic [DATA_W-1:0] d;
    pulse(10'b00_0000_0001);
    rd(4, d); chk("R2 error without transfer", d, 0);
    pulse(10'b00_0000_0011);
    rd(4, d); chk("R2 error during transfer", d, 32'h1);
    wr(2, 32'h1);
    rd(4, d); chk("R9 ack bus fault", d, 0);
  endtask

  task automatic t_fifo;
    logic [DATA_W-1:0] d;
    pulse(10'b00_0000_0100);
    pulse(10'b00_0010_0000);
    rd(4, d); chk("R3 no fault conditions", d, 0);
    pulse(10'b00_0000_1100);
    rd(4, d); chk("R3 underflow", d, 32'h2);
    pulse(10'b00_0011_0000);
    rd(4, d); chk("R3 overwrite", d, 32'h6);
    wr(2, 32'hFFFF_FFF9);
    rd(4, d); chk("R9 zero bits keep status", d, 32'h6);
    wr(2, 32'h6);
    rd(4, d); chk("R9 ack fifo bits", d, 0);
  endtask

  task automatic t_frame;
    logic [DATA_W-1:0] d;
    pulse(10'b00_0100_0000);
    rd(4, d); chk("R4 frame end", d, 32'h8);
    wr(2, 32'h8);
  endtask

  task automatic t_line;
    logic [DATA_W-1:0] d;
    pulse(10'b11_1000_0000);
    rd(4, d); chk("R5 blank while busy", d, 0);
    pulse(10'b00_1000_0000);
    rd(4, d); chk("R5 line end", d, 32'h10);
    pulse(10'b01_1000_0000);
    rd(4, d); chk("R5 last line end", d, 32'h30);
    wr(2, 32'h30);
  endtask

  task automatic t_mask;
    logic [DATA_W-1:0] d;
    wr(0, 32'h5);
    rd(3, d); chk("R7 set mask", d, 32'h5);
    wr(0, 32'h2);
    rd(3, d); chk("R7 zero bits unchanged", d, 32'h7);
    wr(1, 32'h4);
    rd(3, d); chk("R8 clear mask bit", d, 32'h3);
    wr(1, 32'h0);
    rd(3, d); chk("R8 zero write keeps mask", d, 32'h3);
  endtask

  task automatic t_irq;
    logic [DATA_W-1:0] d;
    pulse(10'b00_0100_0000);
    @(negedge clk); chk("R10 masked source quiet", irq, 0);
    rd(4, d); chk("R6 set while masked", d, 32'h8);
    wr(0, 32'h8);
    chk("R10 irq one cycle late", irq, 0);
    @(negedge clk); chk("R10 irq raised", irq, 1);
    wr(1, 32'h8);
    @(negedge clk); chk("R10 irq drops on disable", irq, 0);
    rd(4, d); chk("R6 sticky after disable", d, 32'h8);
    wr(2, 32'h8);
    pulse(10'b00_0000_1100);
    @(negedge clk); chk("R10 underflow irq", irq, 1);
    wr(2, 32'h2);
    chk("R10 irq held a cycle after ack", irq, 1);
    @(negedge clk); chk("R10 irq low after ack", irq, 0);
  endtask

  task automatic t_race;
    logic [DATA_W-1:0] d;
    pulse(10'b00_0100_0000);
    @(negedge clk); req = 1; we = 1; addr = 3'd2; wdata = 32'h8; ev = 10'b00_0100_0000;
    @(negedge clk); req = 0; we = 0; wdata = '0; ev = '0;
    rd(4, d); chk("R9 event beats ack", d, 32'h8);
    @(negedge clk); req = 1; we = 1; addr = 3'd2; wdata = 32'h8; ev = 10'b00_0000_1100;
    @(negedge clk); req = 0; we = 0; wdata = '0; ev = '0;
    rd(4, d); chk("R9 ack with other event", d, 32'h2);
    wr(2, 32'h2);
  endtask

  task automatic t_unmapped;
    logic [DATA_W-1:0] d;
    for (int a = 5; a < 8; a++) begin
      rd(a, d); chk("R11 unmapped read", d, 0);
    end
    pulse(10'b00_0100_0000);
    for (int a = 3; a < 8; a++) wr(a, '1);
    rd(3, d); chk("R11 mask untouched", d, 32'h3);
    rd(4, d); chk("R11 status untouched", d, 32'h8);
    chk("R10 no irq for masked status", irq, 0);
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_bus_fault();
    t_fifo();
    t_frame();
    t_line();
    t_mask();
    t_irq();
    t_race();
    t_unmapped();
    done = 1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule